// File: doc/BRIEF.md
# NOR flash command sequence decoder

This block is the command state machine of a behavioural parallel NOR flash model. It watches bus write cycles. Each cycle is one address and one data word, qualified by a single-cycle write strobe. It recognises the unlock-prefixed command sequences and hands each recognised operation (program, chip erase, sector erase) to the array side. The hand-off is a one-cycle start pulse that carries the operation kind, the address and the data. A busy flag then stays high until the array side reports completion. The block also selects what a read returns: array contents, identification codes, or query data.

Every command other than reset and query entry must begin with a fixed two-write unlock pattern at set addresses. A write with the wrong value or the wrong address, at any step of a sequence, silently sends the machine back to array read mode. The array itself is outside this block. It is seen as a combinational read port (`arr_rdata` answers `rd_addr`) and a start/done handshake. Bus width is chosen by `byte_mode`. In byte mode the bus address carries one extra low bit below the word address.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset the read mode is array (`rd_mode` = 0), `busy` and `op_start` are low, and `rd_data` equals `arr_rdata` for any `rd_addr`.
- R2: Writes AAh@K1, 55h@K2, A0h@K1 followed by any write (address A, data D) give exactly one `op_start` pulse. The pulse comes in the cycle after that fourth write, with `op_kind` = 1, `op_addr` = A and `op_data` = D. `busy` rises in the same cycle. Only the low byte of `wr_data` is compared as a command code.
- R3: Writes AAh@K1, 55h@K2, 80h@K1, AAh@K1, 55h@K2, 10h@K1 give one `op_start` pulse with `op_kind` = 2.
- R4: The same first five writes followed by 30h at any address S give one `op_start` pulse with `op_kind` = 3 and `op_addr` = S.
- R5: The key addresses are K1 = 555h, K2 = 2AAh and KQ = 55h. In word mode they are compared on `wr_addr[10:0]`. In byte mode they are compared on `wr_addr[11:0]` as AAAh, 555h and AAh. Higher address bits are ignored.
- R6: A write with a wrong code or a wrong key address at any unfinished step abandons the sequence. No operation starts and the read mode stays array. The offending write does not itself begin a new sequence. F0h at any unfinished step has the same effect.
- R7: AAh@K1, 55h@K2, 90h@K1 select identification mode (`rd_mode` = 1). Take W as the word address (`rd_addr` in word mode, `rd_addr[20:1]` in byte mode). If W[1:0] = 0 the read returns C2h. If W[1:0] = 1 it returns the device code: C4h in byte mode or 22C4h in word mode for the top-boot variant, and 49h or 2249h for the bottom-boot variant. Upper byte is zero in byte mode.
- R8: In identification mode, W[1:0] = 2 with W[6] = 0 returns 0001h if `prot_vec` bit W[19:15] is set and 0000h if it is clear. W[1:0] = 2 with W[6] = 1, and W[1:0] = 3, return 0000h.
- R9: In array mode and with no sequence under way, 98h@KQ selects query mode (`rd_mode` = 2). There, W = 10h, 11h and 12h return 51h, 52h and 59h, and every other W returns 0000h.
- R10: In identification or query mode, F0h (any address) returns to array mode and every other write is ignored.
- R11: While `busy` is high, every write (F0h included) is ignored. `busy` falls in the cycle after `op_done` is sampled high, and the next write may begin a new sequence at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_mode | input | 1 | 1 = byte bus, 0 = word bus |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | 21 | Bus write address |
| wr_data | input | 16 | Bus write data (command in low byte) |
| rd_addr | input | 21 | Bus read address |
| rd_data | output | 16 | Read data for `rd_addr` in the current mode |
| arr_rdata | input | 16 | Array contents at `rd_addr` |
| prot_vec | input | 32 | Per-sector protection flags |
| op_start | output | 1 | One-cycle operation start pulse |
| op_kind | output | 2 | 1 program, 2 chip erase, 3 sector erase |
| op_addr | output | 21 | Address for the operation |
| op_data | output | 16 | Data for a program operation |
| op_done | input | 1 | Array side completion |
| busy | output | 1 | Operation in progress |
| rd_mode | output | 2 | 0 array, 1 identification, 2 query |

## Verification
The assertions check the rules that hold on every cycle. A start pulse lasts one cycle and always comes with busy. Busy rises only through a start and holds until done. The read mode moves only in the cycle after a write and never while busy. In array mode the read port passes array data straight through. Sequence recognition, the rejection of corrupted steps at each position, key-address matching in both bus widths, and the identification, protection and query read maps can only be shown by the bench's directed and randomly corrupted sequences.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_UNL1 = 3'd1,
        ST_UNL2 = 3'd2,
        ST_PROG = 3'd3,
        ST_ERA1 = 3'd4,
        ST_ERA2 = 3'd5,
        ST_ERA3 = 3'd6,
        ST_BUSY = 3'd7
    } seq_st_t;

    typedef enum logic [1:0] {
        RM_ARRAY = 2'd0,
        RM_ID    = 2'd1,
        RM_QUERY = 2'd2
    } rd_mode_t;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_CHIP = 2'd2,
        OP_SECT = 2'd3
    } op_kind_t;

    localparam logic [7:0] CMD_KEY1   = 8'hAA;
    localparam logic [7:0] CMD_KEY2   = 8'h55;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ERASE  = 8'h80;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_QUERY  = 8'h98;
    localparam logic [7:0] CMD_CHIP   = 8'h10;
    localparam logic [7:0] CMD_SECT   = 8'h30;
    localparam logic [7:0] CMD_RESET  = 8'hF0;

    localparam logic [7:0] MFR_CODE   = 8'hC2;

endpackage

// File: rtl/nor_unlock_match.sv
module nor_unlock_match (
    input  logic        byte_mode,
    input  logic [11:0] addr_lo,
    output logic        hit_k1,
    output logic        hit_k2,
    output logic        hit_kq
);
    localparam logic [10:0] W_K1 = 11'h555;
    localparam logic [10:0] W_K2 = 11'h2AA;
    localparam logic [10:0] W_KQ = 11'h055;
    localparam logic [11:0] B_K1 = 12'hAAA;
    localparam logic [11:0] B_K2 = 12'h555;
    localparam logic [11:0] B_KQ = 12'h0AA;

    always_comb begin
        if (byte_mode) begin
            hit_k1 = (addr_lo == B_K1);
            hit_k2 = (addr_lo == B_K2);
            hit_kq = (addr_lo == B_KQ);
        end else begin
            hit_k1 = (addr_lo[10:0] == W_K1);
            hit_k2 = (addr_lo[10:0] == W_K2);
            hit_kq = (addr_lo[10:0] == W_KQ);
        end
    end
endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int AW = 21,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          hit_k1,
    input  logic          hit_k2,
    input  logic          hit_kq,
    input  logic          op_done,
    output logic          op_start,
    output logic [1:0]    op_kind,
    output logic [AW-1:0] op_addr,
    output logic [DW-1:0] op_data,
    output logic          busy,
    output logic [1:0]    rd_mode
);
    typedef struct packed {
        seq_st_t       st;
        rd_mode_t      mode;
        logic          start;
        op_kind_t      kind;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } fsm_t;

    fsm_t r_q, r_d;
    logic [7:0] cmd;

    assign cmd = wr_data[7:0];

    always_comb begin
        r_d       = r_q;
        r_d.start = 1'b0;
        if (r_q.st == ST_BUSY) begin
            if (op_done) r_d.st = ST_IDLE;
        end else if (wr_en) begin
            case (r_q.st)
                ST_IDLE: begin
                    if (r_q.mode != RM_ARRAY) begin
                        if (cmd == CMD_RESET) r_d.mode = RM_ARRAY;
                    end else if (cmd == CMD_QUERY && hit_kq) begin
                        r_d.mode = RM_QUERY;
                    end else if (cmd == CMD_KEY1 && hit_k1) begin
                        r_d.st = ST_UNL1;
                    end
                end
                ST_UNL1: r_d.st = (cmd == CMD_KEY2 && hit_k2) ? ST_UNL2 : ST_IDLE;
                ST_UNL2: begin
                    r_d.st = ST_IDLE;
                    if (hit_k1) begin
                        case (cmd)
                            CMD_PROG:  r_d.st   = ST_PROG;
                            CMD_ERASE: r_d.st   = ST_ERA1;
                            CMD_IDENT: r_d.mode = RM_ID;
                            default:   r_d.st   = ST_IDLE;
                        endcase
                    end
                end
                ST_PROG: begin
                    r_d.st    = ST_BUSY;
                    r_d.start = 1'b1;
                    r_d.kind  = OP_PROG;
                    r_d.addr  = wr_addr;
                    r_d.data  = wr_data;
                end
                ST_ERA1: r_d.st = (cmd == CMD_KEY1 && hit_k1) ? ST_ERA2 : ST_IDLE;
                ST_ERA2: r_d.st = (cmd == CMD_KEY2 && hit_k2) ? ST_ERA3 : ST_IDLE;
                ST_ERA3: begin
                    if (cmd == CMD_CHIP && hit_k1) begin
                        r_d.st    = ST_BUSY;
                        r_d.start = 1'b1;
                        r_d.kind  = OP_CHIP;
                        r_d.addr  = wr_addr;
                        r_d.data  = '0;
                    end else if (cmd == CMD_SECT) begin
                        r_d.st    = ST_BUSY;
                        r_d.start = 1'b1;
                        r_d.kind  = OP_SECT;
                        r_d.addr  = wr_addr;
                        r_d.data  = '0;
                    end else begin
                        r_d.st = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st    <= ST_IDLE;
            r_q.mode  <= RM_ARRAY;
            r_q.start <= 1'b0;
            r_q.kind  <= OP_NONE;
            r_q.addr  <= '0;
            r_q.data  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign op_start = r_q.start;
    assign op_kind  = r_q.kind;
    assign op_addr  = r_q.addr;
    assign op_data  = r_q.data;
    assign busy     = (r_q.st == ST_BUSY);
    assign rd_mode  = r_q.mode;
endmodule

// File: rtl/nor_read_mux.sv
module nor_read_mux
    import nor_cmd_pkg::*;
#(
    parameter int WORD_AW   = 20,
    parameter int SECT_LOG2 = 15,
    parameter bit TOP_BOOT  = 1'b1,
    parameter int NSECT     = 32
) (
    input  logic               byte_mode,
    input  logic [1:0]         rd_mode,
    input  logic [WORD_AW:0]   rd_addr,
    input  logic [15:0]        arr_rdata,
    input  logic [NSECT-1:0]   prot_vec,
    output logic [15:0]        rd_data
);
    localparam int SIDX_W = WORD_AW - SECT_LOG2;

    logic [WORD_AW-1:0] wa;
    logic [SIDX_W-1:0]  sidx;
    logic [7:0]         dev_lo;
    logic [15:0]        id_val;
    logic [15:0]        qry_val;

    assign wa   = byte_mode ? rd_addr[WORD_AW:1] : rd_addr[WORD_AW-1:0];
    assign sidx = wa[WORD_AW-1:SECT_LOG2];

    generate
        if (TOP_BOOT) begin : g_top
            assign dev_lo = 8'hC4;
        end else begin : g_bot
            assign dev_lo = 8'h49;
        end
    endgenerate

    always_comb begin
        case (wa[1:0])
            2'b00:   id_val = {8'h00, MFR_CODE};
            2'b01:   id_val = byte_mode ? {8'h00, dev_lo} : {8'h22, dev_lo};
            2'b10:   id_val = wa[6] ? 16'h0000 : {15'd0, prot_vec[sidx]};
            default: id_val = 16'h0000;
        endcase
    end

    always_comb begin
        if (wa == WORD_AW'(8'h10))      qry_val = 16'h0051;
        else if (wa == WORD_AW'(8'h11)) qry_val = 16'h0052;
        else if (wa == WORD_AW'(8'h12)) qry_val = 16'h0059;
        else                            qry_val = 16'h0000;
    end

    always_comb begin
        case (rd_mode)
            RM_ID:    rd_data = id_val;
            RM_QUERY: rd_data = qry_val;
            default:  rd_data = arr_rdata;
        endcase
    end
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder #(
    parameter int WORD_AW   = 20,
    parameter int SECT_LOG2 = 15,
    parameter bit TOP_BOOT  = 1'b1,
    parameter int DW        = 16,
    parameter int AW        = WORD_AW + 1,
    parameter int NSECT     = 1 << (WORD_AW - SECT_LOG2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_mode,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [DW-1:0]    wr_data,
    input  logic [AW-1:0]    rd_addr,
    output logic [15:0]      rd_data,
    input  logic [15:0]      arr_rdata,
    input  logic [NSECT-1:0] prot_vec,
    output logic             op_start,
    output logic [1:0]       op_kind,
    output logic [AW-1:0]    op_addr,
    output logic [DW-1:0]    op_data,
    input  logic             op_done,
    output logic             busy,
    output logic [1:0]       rd_mode
);
    logic hit_k1, hit_k2, hit_kq;

    nor_unlock_match u_match (
        .byte_mode (byte_mode),
        .addr_lo   (wr_addr[11:0]),
        .hit_k1    (hit_k1),
        .hit_k2    (hit_k2),
        .hit_kq    (hit_kq)
    );

    nor_seq_fsm #(.AW(AW), .DW(DW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .hit_k1   (hit_k1),
        .hit_k2   (hit_k2),
        .hit_kq   (hit_kq),
        .op_done  (op_done),
        .op_start (op_start),
        .op_kind  (op_kind),
        .op_addr  (op_addr),
        .op_data  (op_data),
        .busy     (busy),
        .rd_mode  (rd_mode)
    );

    nor_read_mux #(
        .WORD_AW(WORD_AW), .SECT_LOG2(SECT_LOG2),
        .TOP_BOOT(TOP_BOOT), .NSECT(NSECT)
    ) u_rmux (
        .byte_mode (byte_mode),
        .rd_mode   (rd_mode),
        .rd_addr   (rd_addr),
        .arr_rdata (arr_rdata),
        .prot_vec  (prot_vec),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        op_start,
    input logic        op_done,
    input logic        busy,
    input logic [1:0]  rd_mode,
    input logic [15:0] rd_data,
    input logic [15:0] arr_rdata
);
    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |-> busy);

    // R2
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    // R11
    busy_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> op_start);

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !op_done) |=> busy);

    // R11
    busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_done) |=> !busy);

    // R10
    mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || busy) |=> $stable(rd_mode));

    // R1
    array_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_mode == 2'd0) |-> (rd_data == arr_rdata));
endmodule

bind nor_cmd_decoder nor_cmd_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .op_start  (op_start),
    .op_done   (op_done),
    .busy      (busy),
    .rd_mode   (rd_mode),
    .rd_data   (rd_data),
    .arr_rdata (arr_rdata)
);

// File: tb/sim_nor_cmd_decoder.sv
module sim_nor_cmd_decoder;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        byte_mode = 1'b0;
    logic        wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] arr_rdata;
    logic [31:0] prot_vec = '0;
    logic        op_start;
    logic [1:0]  op_kind;
    logic [AW-1:0] op_addr;
    logic [15:0] op_data;
    logic        op_done = 1'b0;
    logic        busy;
    logic [1:0]  rd_mode;

    int n_vec = 0;
    int n_bad = 0;
    int n_starts = 0;
    logic [1:0]  last_kind;
    logic [AW-1:0] last_addr;
    logic [15:0] last_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign arr_rdata = 16'h1357 ^ rd_addr[15:0];

    nor_cmd_decoder u0 (
        .clk(clk), .rst_n(rst_n), .byte_mode(byte_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .arr_rdata(arr_rdata),
        .prot_vec(prot_vec), .op_start(op_start), .op_kind(op_kind),
        .op_addr(op_addr), .op_data(op_data), .op_done(op_done),
        .busy(busy), .rd_mode(rd_mode)
    );

    always @(negedge clk) begin
        if (op_start) begin
            n_starts  = n_starts + 1;
            last_kind = op_kind;
            last_addr = op_addr;
            last_data = op_data;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_addr = a;
        #1 v = rd_data;
    endtask

    task automatic finish_op();
        repeat (2) @(negedge clk);
        op_done = 1'b1;
        @(negedge clk);
        op_done = 1'b0;
        #1 chk("R11 busy falls after done", busy, 0);
    endtask

    function automatic logic [AW-1:0] k1(input bit bm, input logic [9:0] h);
        return bm ? {h[8:0], 12'hAAA} : {h, 11'h555};
    endfunction
    function automatic logic [AW-1:0] k2(input bit bm, input logic [9:0] h);
        return bm ? {h[8:0], 12'h555} : {h, 11'h2AA};
    endfunction
    function automatic logic [AW-1:0] kq(input bit bm, input logic [9:0] h);
        return bm ? {h[8:0], 12'h0AA} : {h, 11'h055};
    endfunction
    function automatic logic [AW-1:0] waddr(input bit bm, input logic [19:0] w);
        return bm ? {w, 1'b0} : {1'b0, w};
    endfunction
    function automatic logic [15:0] dev_code(input bit bm);
        return bm ? 16'h00C4 : 16'h22C4;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int s0;
        void'($urandom(32'd4242));
        prot_vec = $urandom;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk("R1 busy", busy, 0);
        chk("R1 op_start", op_start, 0);
        chk("R1 mode", rd_mode, 0);
        rd(21'h5, v); chk("R1 array read", v, 16'h1357 ^ 16'h5);

        // R6 F0 mid-sequence, then tail alone must not act
        s0 = n_starts;
        wr(k1(0,0), 16'hAA); wr(0, 16'hF0);
        wr(k2(0,0), 16'h55); wr(k1(0,0), 16'h90);
        @(negedge clk); #1 chk("R6 F0 abort", rd_mode, 0);

        // R6 offending write does not restart
        wr(k1(0,0), 16'hAA); wr(k1(0,0), 16'hAA);
        wr(k2(0,0), 16'h55); wr(k1(0,0), 16'hA0); wr(21'h123, 16'h4444);
        @(negedge clk); #1 chk("R6 no restart", n_starts - s0, 0);
        chk("R6 not busy", busy, 0);

        // R2 program data F0 is data, not reset
        wr(k1(0,0), 16'hAA); wr(k2(0,0), 16'h55); wr(k1(0,0), 16'hA0);
        wr(21'h0ABCD, 16'h00F0);
        @(negedge clk); #1;
        chk("R2 start count", n_starts - s0, 1);
        chk("R2 kind", last_kind, 1);
        chk("R2 addr", last_addr, 21'h0ABCD);
        chk("R2 data", last_data, 16'h00F0);
        chk("R2 busy", busy, 1);
        // R11 F0 ignored while busy
        wr(0, 16'hF0);
        @(negedge clk); #1 chk("R11 F0 ignored busy", busy, 1);
        finish_op();
        // R3 immediately after done
        s0 = n_starts;
        wr(k1(0,1), 16'hAA); wr(k2(0,2), 16'h55); wr(k1(0,3), 16'h80);
        wr(k1(0,4), 16'hAA); wr(k2(0,5), 16'h55); wr(k1(0,6), 16'h10);
        @(negedge clk); #1;
        chk("R3 count", n_starts - s0, 1);
        chk("R3 kind", last_kind, 2);
        finish_op();

        for (int t = 0; t < 300; t++) begin
            logic [AW-1:0] sa [6];
            logic [15:0]   sd [6];
            int len, cmd, pos, sent;
            bit bm, bad;
            logic [15:0] pd;
            logic [AW-1:0] pa;
            @(negedge clk);
            bm = 1'($urandom % 2);
            byte_mode = bm;
            cmd = $urandom % 5;
            pa = AW'($urandom);
            pd = 16'($urandom);
            sa[0] = k1(bm, 10'($urandom)); sd[0] = 16'hAA;
            sa[1] = k2(bm, 10'($urandom)); sd[1] = 16'h55;
            len = 3;
            case (cmd)
                0: begin sa[2] = k1(bm, 10'($urandom)); sd[2] = 16'hA0;
                         sa[3] = pa; sd[3] = pd; len = 4; end
                1, 2: begin
                    sa[2] = k1(bm, 10'($urandom)); sd[2] = 16'h80;
                    sa[3] = k1(bm, 10'($urandom)); sd[3] = 16'hAA;
                    sa[4] = k2(bm, 10'($urandom)); sd[4] = 16'h55;
                    if (cmd == 1) begin sa[5] = k1(bm, 10'($urandom)); sd[5] = 16'h10; end
                    else begin sa[5] = pa; sd[5] = 16'h30; end
                    len = 6;
                end
                3: begin sa[2] = k1(bm, 10'($urandom)); sd[2] = 16'h90; end
                default: begin sa[0] = kq(bm, 10'($urandom)); sd[0] = 16'h98; len = 1; end
            endcase
            bad = ($urandom % 3) == 0;
            pos = $urandom % ((cmd == 0) ? 3 : len);
            if (bad) begin
                if ((cmd == 2 && pos == 5) || ($urandom % 2) == 0) sd[pos] = sd[pos] ^ 16'h0001;
                else sa[pos] = sa[pos] ^ 21'h1;
            end
            sent = bad ? pos + 1 : len;
            s0 = n_starts;
            for (int i = 0; i < sent; i++) wr(sa[i], sd[i]);
            @(negedge clk); #1;
            if (bad) begin
                chk("R6 corrupt no start", n_starts - s0, 0);
                chk("R6 corrupt mode", rd_mode, 0);
                chk("R6 corrupt busy", busy, 0);
                rd(0, v); chk("R6 corrupt array read", v, 16'h1357);
            end else if (cmd <= 2) begin
                chk("R5 op count", n_starts - s0, 1);
                chk("R2 R3 R4 kind", last_kind, (cmd == 0) ? 2'd1 : (cmd == 1) ? 2'd2 : 2'd3);
                if (cmd != 1) chk("R2 R4 addr", last_addr, pa);
                if (cmd == 0) chk("R2 data", last_data, pd);
                chk("R11 busy up", busy, 1);
                wr(k1(bm, 0), 16'hAA);
                @(negedge clk); #1 chk("R11 write ignored", busy, 1);
                finish_op();
            end else if (cmd == 3) begin
                chk("R7 mode", rd_mode, 1);
                rd(waddr(bm, 20'h0), v); chk("R7 mfr", v, 16'h00C2);
                rd(waddr(bm, 20'h1), v); chk("R7 device", v, dev_code(bm));
                s0 = $urandom % 32;
                rd(waddr(bm, {5'(s0), 15'h0002}), v);
                chk("R8 protect", v, {15'd0, prot_vec[s0]});
                rd(waddr(bm, {5'(s0), 15'h0042}), v); chk("R8 A6 high", v, 0);
                wr(k1(bm, 0), 16'hAA); wr(k2(bm, 0), 16'h55); wr(k1(bm, 0), 16'hA0);
                @(negedge clk); #1 chk("R10 id ignores", rd_mode, 1);
                wr(21'h777, 16'hF0);
                @(negedge clk); #1 chk("R10 id exit", rd_mode, 0);
            end else begin
                chk("R9 mode", rd_mode, 2);
                rd(waddr(bm, 20'h10), v); chk("R9 Q", v, 16'h0051);
                rd(waddr(bm, 20'h11), v); chk("R9 R", v, 16'h0052);
                rd(waddr(bm, 20'h12), v); chk("R9 Y", v, 16'h0059);
                rd(waddr(bm, 20'h13), v); chk("R9 other", v, 16'h0000);
                wr(k1(bm, 0), 16'hAA);
                @(negedge clk); #1 chk("R10 query ignores", rd_mode, 2);
                wr(21'h0, 16'hF0);
                @(negedge clk); #1 chk("R10 query exit", rd_mode, 0);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule